// File: doc/BRIEF.md
# Byte-Lane Synchronous Memory Port Control

This block is the control logic of one port of a synchronous static memory whose 36-bit word is split into four 9-bit byte lanes. On every rising clock edge it samples a pair of chip enables of opposite polarity, four active-low lane enables and a read/write strobe. From them it builds per-lane write strobes into a behavioural memory array and per-lane read captures.

The lane-drive vector, which stands in for the tri-state output buffers of each lane, is gated without any clock by an active-low output enable and a sleep input. A read lane is driven only when the gating allows it. A static parameter sets flow-through or pipelined read timing. In pipelined mode the read data and its drive mask arrive one clock later than in flow-through mode.

Top module: `bytelane_port`

## Requirements
- R1: Lane l occupies bits [9l+8 : 9l] of both data words, so lane 0 is bits 8..0 and lane 3 is bits 35..27. Lane enable bit byteEnN[l] controls lane l only.
- R2: The port is selected only when ceLo=0 and ceHi=1. With ceLo=1 and ceHi=0 the port is deselected: no write takes place and the lane-drive vector stays zero.
- R3: The enable pairs ceLo=ceHi=0 and ceLo=ceHi=1 are illegal and perform no write and no read. When such a pair is sampled with sleep low, illegalSel is 1 in the cycle after that edge. Otherwise illegalSel is 0.
- R4: A selected write (rdWrN=0) updates exactly the lanes at addr whose byteEnN bit is 0. Every other lane keeps its contents, and any mix of lanes is allowed.
- R5: In flow-through mode, a selected read (rdWrN=1) sampled at an edge sets laneDrive to the inverse of the sampled byteEnN in the cycle after that edge. rdData then carries the stored lanes at that address. Undriven lanes read as zero.
- R6: With all four byteEnN bits at 1, a selected access changes no lane and drives no lane.
- R7: While outEnN is 1, laneDrive and rdData are zero at once, with no clock edge needed.
- R8: While sleep is 1, laneDrive and rdData are zero at once. An edge sampled with sleep high performs no write, no read and raises no illegal flag.
- R9: While rdWrN is 0, laneDrive is zero, because the lanes are acting as inputs.
- R10: With PIPELINED=1, read data and lane drive follow the flow-through timing exactly one cycle later.
- R11: While rstN is low, laneDrive, rdData and illegalSel are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceLo | input | 1 | Chip enable, active low |
| ceHi | input | 1 | Chip enable, active high |
| byteEnN | input | 4 | Per-lane enables, active low |
| rdWrN | input | 1 | 1 = read, 0 = write |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, overrides everything |
| addr | input | ADDR_W | Word address |
| wrData | input | 36 | Write data, four 9-bit lanes |
| rdData | output | 36 | Read data, undriven lanes zero |
| laneDrive | output | 4 | Per-lane output-driver enable |
| illegalSel | output | 1 | Illegal chip-enable pair sampled last edge |

## Verification
The bench runs two copies of the port side by side, one flow-through and one pipelined, and compares both against one reference memory. Single-lane and partial writes followed by full reads separate correct lane placement from a swapped or shifted mask. Writes with all lanes disabled, and writes under illegal or deselecting enable pairs, show that protection holds across the whole word. The output enable and sleep are toggled in the middle of a cycle to show that their gating needs no clock, and random traffic covers the ordering of reads and writes across the pipeline stage.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef struct packed {
    logic [LANES-1:0] wrLane;
    logic [LANES-1:0] rdLane;
    logic             rdEn;
  } laneStrobes_t;
endpackage

// File: rtl/bytelane_ctrl.sv
module bytelane_ctrl
  import bytelane_pkg::*;
#(
  parameter bit PIPELINED = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceLo,
  input  logic             ceHi,
  input  logic [LANES-1:0] byteEnN,
  input  logic             rdWrN,
  input  logic             outEnN,
  input  logic             sleep,
  output laneStrobes_t     strobes,
  output logic [LANES-1:0] laneDrive,
  output logic             illegalSel
);
  logic             portSel;
  logic             pairBad;
  logic [LANES-1:0] maskStage1;
  logic [LANES-1:0] maskOut;
  logic             driveGate;

  assign portSel = !ceLo && ceHi && !sleep;
  assign pairBad = (ceLo == ceHi);

  always_comb begin
    strobes        = '0;
    strobes.wrLane = (portSel && !rdWrN) ? ~byteEnN : '0;
    strobes.rdLane = (portSel &&  rdWrN) ? ~byteEnN : '0;
    strobes.rdEn   = |strobes.rdLane;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskStage1 <= '0;
      illegalSel <= 1'b0;
    end else begin
      maskStage1 <= strobes.rdLane;
      illegalSel <= pairBad && !sleep;
    end
  end

  generate
    if (PIPELINED) begin : g_pipe
      logic [LANES-1:0] maskStage2;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) maskStage2 <= '0;
        else       maskStage2 <= maskStage1;
      end
      assign maskOut = maskStage2;
    end else begin : g_flow
      assign maskOut = maskStage1;
    end
  endgenerate

  assign driveGate = !outEnN && !sleep && rdWrN;
  assign laneDrive = maskOut & {LANES{driveGate}};

  a_r3_illegal_flag: assert property (@(posedge clk) disable iff (!rstN)
    (pairBad && !sleep) |=> illegalSel);
  a_r3_illegal_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    pairBad |-> (strobes.wrLane == '0 && !strobes.rdEn));
  a_r8_sleep_blocks: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (strobes.wrLane == '0 && laneDrive == '0 && !strobes.rdEn));
  a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rdWrN |-> (laneDrive == '0));
  a_r7_oe_quiet: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (laneDrive == '0));
endmodule

// File: rtl/bytelane_datapath.sv
module bytelane_datapath
  import bytelane_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter bit PIPELINED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LANES-1:0]  laneDrive,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  a_r4_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.wrLane) |-> !strobes.rdEn);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] laneMem [DEPTH];
      logic [LANE_W-1:0] stage1;
      logic [LANE_W-1:0] laneOut;

      always_ff @(posedge clk) begin
        if (strobes.wrLane[l]) laneMem[addr] <= wrData[l*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 stage1 <= '0;
        else if (strobes.rdLane[l]) stage1 <= laneMem[addr];
      end

      if (PIPELINED) begin : g_pipe
        logic [LANE_W-1:0] stage2;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage2 <= '0;
          else       stage2 <= stage1;
        end
        assign laneOut = stage2;
      end else begin : g_flow
        assign laneOut = stage1;
      end

      assign rdData[l*LANE_W +: LANE_W] = laneDrive[l] ? laneOut : '0;

      a_r4_lane_write: assert property (@(posedge clk) disable iff (!rstN)
        strobes.wrLane[l] |=> (laneMem[$past(addr)] == $past(wrData[l*LANE_W +: LANE_W])));
    end
  endgenerate
endmodule

// File: rtl/bytelane_port.sv
module bytelane_port
  import bytelane_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter bit PIPELINED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceLo,
  input  logic              ceHi,
  input  logic [LANES-1:0]  byteEnN,
  input  logic              rdWrN,
  input  logic              outEnN,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic [LANES-1:0]  laneDrive,
  output logic              illegalSel
);
  laneStrobes_t strobes;

  bytelane_ctrl #(.PIPELINED(PIPELINED)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceLo(ceLo), .ceHi(ceHi), .byteEnN(byteEnN),
    .rdWrN(rdWrN), .outEnN(outEnN), .sleep(sleep), .strobes(strobes),
    .laneDrive(laneDrive), .illegalSel(illegalSel)
  );

  bytelane_datapath #(.ADDR_W(ADDR_W), .PIPELINED(PIPELINED)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr), .wrData(wrData),
    .laneDrive(laneDrive), .rdData(rdData)
  );
endmodule

// File: tb/tb_bytelane_port.sv
`timescale 1ns/1ps
module tb_bytelane_port;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceLo = 1'b0, ceHi = 1'b1, rdWrN = 1'b1, outEnN = 1'b0, sleep = 1'b0;
  logic [3:0] byteEnN = 4'hF;
  logic [ADDR_W-1:0] addr = '0;
  logic [35:0] wrData = '0;
  logic [35:0] rdFlow, rdPipe;
  logic [3:0] drvFlow, drvPipe;
  logic illFlow, illPipe;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [35:0] refMem [DEPTH];
  logic [3:0]  fMask = '0, pMask = '0;
  logic [35:0] fData = '0, pData = '0;
  logic        expIll = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytelane_port #(.ADDR_W(ADDR_W), .PIPELINED(1'b0)) dut (
    .clk(clk), .rstN(rstN), .ceLo(ceLo), .ceHi(ceHi), .byteEnN(byteEnN),
    .rdWrN(rdWrN), .outEnN(outEnN), .sleep(sleep), .addr(addr), .wrData(wrData),
    .rdData(rdFlow), .laneDrive(drvFlow), .illegalSel(illFlow));

  bytelane_port #(.ADDR_W(ADDR_W), .PIPELINED(1'b1)) dutPipe (
    .clk(clk), .rstN(rstN), .ceLo(ceLo), .ceHi(ceHi), .byteEnN(byteEnN),
    .rdWrN(rdWrN), .outEnN(outEnN), .sleep(sleep), .addr(addr), .wrData(wrData),
    .rdData(rdPipe), .laneDrive(drvPipe), .illegalSel(illPipe));

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] gateMask(logic [3:0] m);
    return (!outEnN && !sleep && rdWrN) ? m : 4'h0;
  endfunction

  function automatic logic [35:0] shownData(logic [3:0] drv, logic [35:0] d);
    logic [35:0] r = '0;
    for (int l = 0; l < 4; l++) if (drv[l]) r[l*9 +: 9] = d[l*9 +: 9];
    return r;
  endfunction

  task automatic checkOutputs(string tagF, string tagP);
    logic [3:0] dF = gateMask(fMask);
    logic [3:0] dP = gateMask(pMask);
    chk(tagF, {32'd0, drvFlow}, {32'd0, dF});
    chk(tagF, rdFlow, shownData(dF, fData));
    chk(tagP, {32'd0, drvPipe}, {32'd0, dP});
    chk(tagP, rdPipe, shownData(dP, pData));
    chk("R3 illegal flag", {35'd0, illFlow}, {35'd0, expIll});
    chk("R3 illegal flag pipe", {35'd0, illPipe}, {35'd0, expIll});
  endtask

  task automatic setIn(logic cl, logic ch, logic [3:0] be, logic rw,
                       logic oe, logic sl, logic [ADDR_W-1:0] a, logic [35:0] d);
    ceLo = cl; ceHi = ch; byteEnN = be; rdWrN = rw;
    outEnN = oe; sleep = sl; addr = a; wrData = d;
  endtask

  // one clock: model the edge, then check outputs just after it
  task automatic step(string tagF = "R5 flow read", string tagP = "R10 pipe read");
    logic sel, bad;
    logic [3:0] rdM;
    @(posedge clk);
    sel = !ceLo && ceHi && !sleep;
    bad = (ceLo == ceHi) && !sleep;
    rdM = (sel && rdWrN) ? ~byteEnN : 4'h0;
    pMask = fMask;
    pData = fData;
    for (int l = 0; l < 4; l++) if (rdM[l]) fData[l*9 +: 9] = refMem[addr][l*9 +: 9];
    fMask = rdM;
    if (sel && !rdWrN)
      for (int l = 0; l < 4; l++)
        if (!byteEnN[l]) refMem[addr][l*9 +: 9] = wrData[l*9 +: 9];
    expIll = bad;
    #1;
    checkOutputs(tagF, tagP);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R11: reset state
    repeat (3) @(negedge clk);
    checkOutputs("R11 reset", "R11 reset pipe");
    rstN = 1'b1;
    @(negedge clk);

    // R4: fill every word with all lanes
    for (int a = 0; a < DEPTH; a++) begin
      setIn(0, 1, 4'h0, 0, 0, 0, a[ADDR_W-1:0], {$urandom, $urandom} & 36'hF_FFFF_FFFF);
      step("R9 write quiet", "R9 write quiet pipe");
    end

    // R1: single lane 2 lands in bits 26..18
    setIn(0, 1, 4'h0, 0, 0, 0, 6'd5, 36'd0);           step("R4 write");
    setIn(0, 1, 4'b1011, 0, 0, 0, 6'd5, {9'h0, 9'h1A5, 18'h0}); step("R4 lane2 write");
    setIn(0, 1, 4'h0, 1, 0, 0, 6'd5, 36'd0);           step("R1 read");
    chk("R1 lane2 bits", rdFlow, {9'h0, 9'h1A5, 18'h0});
    setIn(0, 1, 4'hF, 1, 0, 0, 6'd5, 36'd0);           step("R10 pipe delay");
    chk("R10 pipe lane2", rdPipe, {9'h0, 9'h1A5, 18'h0});

    // R6: no lanes enabled, write then read back
    setIn(0, 1, 4'hF, 0, 0, 0, 6'd5, 36'hF_FFFF_FFFF); step("R6 no lane write");
    setIn(0, 1, 4'hF, 1, 0, 0, 6'd5, 36'd0);           step("R6 no lane read");
    setIn(0, 1, 4'h0, 1, 0, 0, 6'd5, 36'd0);           step("R6 readback");

    // R3: illegal pairs, R2: deselect
    setIn(0, 0, 4'h0, 0, 0, 0, 6'd8, 36'hA_AAAA_AAAA); step("R3 illegal lowlow");
    setIn(1, 1, 4'h0, 1, 0, 0, 6'd8, 36'd0);           step("R3 illegal highhigh");
    setIn(1, 0, 4'h0, 0, 0, 0, 6'd8, 36'h5_5555_5555); step("R2 deselect write");
    setIn(1, 0, 4'h0, 1, 0, 0, 6'd8, 36'd0);           step("R2 deselect read");
    setIn(0, 1, 4'h0, 1, 0, 0, 6'd8, 36'd0);           step("R2 readback");

    // R7 / R8: asynchronous gating mid-cycle
    setIn(0, 1, 4'b0110, 1, 0, 0, 6'd9, 36'd0);
    @(posedge clk); #1;
    chk("R5 drive from enables", {32'd0, drvFlow}, 36'h9);
    outEnN = 1'b1; #1;
    chk("R7 oe async drive", {32'd0, drvFlow}, 36'd0);
    chk("R7 oe async data", rdFlow, 36'd0);
    outEnN = 1'b0; sleep = 1'b1; #1;
    chk("R8 sleep async drive", {32'd0, drvFlow}, 36'd0);
    chk("R8 sleep async data", rdFlow, 36'd0);
    sleep = 1'b0; #1;
    chk("R7 restore drive", {32'd0, drvFlow}, 36'h9);
    rdWrN = 1'b0; #1;
    chk("R9 rw low async", {32'd0, drvFlow}, 36'd0);
    rdWrN = 1'b1;
    // resync model for this manual edge
    pMask = fMask; pData = fData;
    fMask = 4'h9;
    for (int l = 0; l < 4; l++) if (fMask[l]) fData[l*9 +: 9] = refMem[9][l*9 +: 9];
    expIll = 1'b0;
    @(negedge clk);

    // R8: sleep at edge blocks write
    setIn(0, 1, 4'h0, 0, 0, 1, 6'd10, 36'hC_3C3C_3C3C); step("R8 sleep write");
    setIn(0, 0, 4'h0, 1, 0, 1, 6'd10, 36'd0);           step("R8 sleep illegal");
    setIn(0, 1, 4'h0, 1, 0, 0, 6'd10, 36'd0);           step("R8 readback");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic cl = 1'b0, ch = 1'b1;
      if (r < 5) begin cl = 1; ch = 0; end
      else if (r < 9) begin cl = 0; ch = 0; end
      else if (r < 12) begin cl = 1; ch = 1; end
      setIn(cl, ch, 4'($urandom), 1'($urandom), ($urandom_range(0, 9) == 0),
            ($urandom_range(0, 19) == 0), ADDR_W'($urandom),
            {$urandom, $urandom} & 36'hF_FFFF_FFFF);
      step("R5 random flow", "R10 random pipe");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule